// File: doc/BRIEF.md
# TDM Transmit Frame Aligner

This block is the transmit framing front end of a time-division-multiplexed serial link. A frame word is loaded in parallel and sent out one bit per bit clock. The first bit leaves a programmable 0 to 3 bit clocks after a frame sync has been latched. The sync can come from the transmit sync line, or from the receive sync line when both directions share one frame timing. The sync is latched on a selectable clock edge. The serial data can be launched on either edge of the bit clock.

Alongside the data path, the block derives a transmit grant for the signalling (D) channel in one of two ways. In the first, a grant pin is sampled while the sync is latched, and the result is gated by an enable bit. In the second, one bit of the receive stream is taken as the grant: that bit is the one whose slot-select code is all ones. The block also reports the index of the bit being driven and gives a one-clock strobe when bit 0 goes out.

A "sync event" is a low-to-high change of the selected sync. The sync is sampled on the rising clock edge, or on the falling edge when `cfg_sync_fall` is set. The block acts on the event at a rising clock edge, here called the event edge.

Top module: `tdm_tx_aligner`

## Requirements
- R1: With delay code `cfg_delay` = d (0 to 3), bit 0 of the frame is driven from the rising edge that comes d clocks after the event edge. With d = 0, bit 0 is driven from the event edge itself.
- R2: Frame bits are driven in order, from `frame_word[0]` to `frame_word[FRAME_LEN-1]`, one per clock. `bit_idx` gives the position of the bit being driven and reads 0 whenever no frame bit is being driven.
- R3: `tx_data` is 1 (idle) before the first frame bit, during the delay clocks and after the last frame bit.
- R4: A sync event during the delay or during a frame drops the frame in progress. Timing restarts from the new event, with the delay code in force at that moment.
- R5: With `cfg_common_sync` = 1, only `rx_sync` produces sync events and `tx_sync` has no effect. With `cfg_common_sync` = 0, only `tx_sync` produces them and `rx_sync` has no effect.
- R6: With `cfg_sync_fall` = 0, the sync is sampled at the rising edge that becomes the event edge. With `cfg_sync_fall` = 1, it is sampled on the falling edge, and the event edge is the next rising edge.
- R7: With `cfg_data_fall` = 0, `tx_data` changes just after the rising edge. With `cfg_data_fall` = 1, it shows the same bit sequence half a clock later, changing on the falling edge.
- R8: With `cfg_grant_gci` = 0, `tx_grant` takes `grant_in & cfg_grant_en` as sampled at the event edge. It holds that value until the next sync event, whatever `grant_in` does in between.
- R9: With `cfg_grant_gci` = 1, a sync event clears `tx_grant` to 0. The first later rising edge at which `rx_slot_code` equals 3'b111 loads `rx_data` into `tx_grant`. Other codes, `grant_in` and further strobes in the same frame have no effect.
- R10: `frame_start` is high for exactly the clock in which bit 0 is driven (rising-edge timing).
- R11: While the synchronous active-low `rst_n` is low, a rising edge sets `tx_data` to 1 and clears `bit_idx`, `frame_start` and `tx_grant` to 0. It also drops any delay or frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_delay | input | 2 | Sync-to-first-bit delay in bit clocks |
| cfg_common_sync | input | 1 | 1: receive sync drives transmit timing |
| cfg_sync_fall | input | 1 | 1: sample the sync on the falling edge |
| cfg_data_fall | input | 1 | 1: launch data on the falling edge |
| cfg_grant_gci | input | 1 | Grant source: 0 grant pin, 1 marked receive bit |
| cfg_grant_en | input | 1 | Enable for the grant-pin mode |
| tx_sync | input | 1 | Transmit frame sync |
| rx_sync | input | 1 | Receive frame sync |
| frame_word | input | FRAME_LEN | Parallel frame to send, bit 0 first |
| grant_in | input | 1 | Grant pin |
| rx_data | input | 1 | Receive serial data |
| rx_slot_code | input | 3 | Slot-select code of the current receive bit |
| tx_data | output | 1 | Transmit serial data |
| bit_idx | output | IDX_W | Index of the bit being driven |
| frame_start | output | 1 | One-clock strobe with bit 0 |
| tx_grant | output | 1 | Signalling-channel transmit grant |

## Verification
The bench builds the block with `FRAME_LEN` = 5, so `bit_idx` is 3 bits wide and a whole frame plus the longest delay fits in ten clocks. That size allows a full sweep: every delay code, both sync edges, both data edges and both sync sources, each with several frame words, checked bit by bit against a position computed from the event edge. Aborts are checked for every second-frame delay. Both grant modes are checked over all enable and pin combinations.

// File: rtl/tdm_aligner_pkg.sv
package tdm_aligner_pkg;

  // slot-select value that marks the receive bit carrying the grant
  localparam logic [2:0] GRANT_SLOT_MARK = 3'b111;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_SHIFT = 2'd2
  } seq_state_e;

  typedef enum logic {
    GRANT_PIN  = 1'b0,
    GRANT_MARK = 1'b1
  } grant_src_e;

  // index width for a frame of len bits (at least one bit)
  function automatic int unsigned idx_bits(input int unsigned len);
    return (len <= 2) ? 1 : $clog2(len);
  endfunction

  // remaining wait clocks once a nonzero delay code has been accepted
  function automatic logic [1:0] wait_preload(input logic [1:0] code);
    return code - 2'd1;
  endfunction

  // low-to-high detect of a sampled sync
  function automatic logic sync_edge(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/tdm_sync_select.sv
module tdm_sync_select
  import tdm_aligner_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_common_sync,
  input  logic cfg_sync_fall,
  input  logic tx_sync,
  input  logic rx_sync,
  output logic sync_evt
);

  logic fall_tx_q;
  logic fall_rx_q;
  logic rise_sel;
  logic fall_sel;
  logic sync_now;
  logic sync_prev_q;

  // falling-edge capture of both sync lines
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      fall_tx_q <= 1'b0;
      fall_rx_q <= 1'b0;
    end else begin
      fall_tx_q <= tx_sync;
      fall_rx_q <= rx_sync;
    end
  end

  assign rise_sel = cfg_common_sync ? rx_sync   : tx_sync;
  assign fall_sel = cfg_common_sync ? fall_rx_q : fall_tx_q;
  assign sync_now = cfg_sync_fall   ? fall_sel  : rise_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_prev_q <= 1'b0;
    else        sync_prev_q <= sync_now;
  end

  assign sync_evt = sync_edge(sync_now, sync_prev_q);

endmodule

// File: rtl/tdm_bit_sequencer.sv
module tdm_bit_sequencer
  import tdm_aligner_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned IDX_W     = idx_bits(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_evt,
  input  logic [1:0]           cfg_delay,
  input  logic [FRAME_LEN-1:0] frame_word,
  output logic                 seq_bit,
  output logic [IDX_W-1:0]     seq_idx,
  output logic                 seq_start,
  output logic                 seq_running,
  output logic                 seq_waiting
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  seq_state_e             state_q;
  logic [1:0]             wait_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   bit_q;
  logic                   start_q;
  logic [FRAME_LEN-1:0]   word_q;
  logic                   start_now;
  logic [IDX_W-1:0]       idx_next;

  // bit 0 goes out at this edge: immediate sync or end of delay
  always_comb begin
    if (sync_evt) start_now = (cfg_delay == 2'd0);
    else          start_now = (state_q == SEQ_WAIT) && (wait_q == 2'd0);
  end

  assign idx_next = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      wait_q  <= 2'd0;
      idx_q   <= '0;
      bit_q   <= 1'b1;
      start_q <= 1'b0;
      word_q  <= '1;
    end else begin
      start_q <= start_now;
      if (start_now) begin
        state_q <= SEQ_SHIFT;
        idx_q   <= '0;
        bit_q   <= frame_word[0];
        word_q  <= frame_word;
      end else if (sync_evt) begin
        state_q <= SEQ_WAIT;
        wait_q  <= wait_preload(cfg_delay);
        idx_q   <= '0;
        bit_q   <= 1'b1;
      end else begin
        case (state_q)
          SEQ_WAIT: wait_q <= wait_q - 2'd1;
          SEQ_SHIFT: begin
            if (idx_q == LAST_IDX) begin
              state_q <= SEQ_IDLE;
              idx_q   <= '0;
              bit_q   <= 1'b1;
            end else begin
              idx_q <= idx_next;
              bit_q <= word_q[idx_next];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign seq_bit     = bit_q;
  assign seq_idx     = idx_q;
  assign seq_start   = start_q;
  assign seq_running = (state_q == SEQ_SHIFT);
  assign seq_waiting = (state_q == SEQ_WAIT);

endmodule

// File: rtl/tdm_grant_unit.sv
module tdm_grant_unit
  import tdm_aligner_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_evt,
  input  logic       cfg_grant_gci,
  input  logic       cfg_grant_en,
  input  logic       grant_in,
  input  logic       rx_data,
  input  logic [2:0] rx_slot_code,
  output logic       mark_strobe,
  output logic       grant
);

  grant_src_e src;
  logic       grant_q;
  logic       armed_q;

  assign src         = grant_src_e'(cfg_grant_gci);
  assign mark_strobe = (rx_slot_code == GRANT_SLOT_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (sync_evt) begin
      if (src == GRANT_PIN) begin
        grant_q <= grant_in & cfg_grant_en;
        armed_q <= 1'b0;
      end else begin
        grant_q <= 1'b0;
        armed_q <= 1'b1;
      end
    end else if (src == GRANT_MARK && armed_q && mark_strobe) begin
      grant_q <= rx_data;
      armed_q <= 1'b0;
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/tdm_data_launch.sv
module tdm_data_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_data_fall,
  input  logic rise_bit,
  output logic tx_data
);

  logic fall_bit_q;

  // half-clock retime of the rising-edge bit
  always_ff @(negedge clk) begin
    if (!rst_n) fall_bit_q <= 1'b1;
    else        fall_bit_q <= rise_bit;
  end

  assign tx_data = cfg_data_fall ? fall_bit_q : rise_bit;

endmodule

// File: rtl/tdm_tx_aligner.sv
module tdm_tx_aligner
  import tdm_aligner_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned IDX_W    = idx_bits(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_delay,
  input  logic                 cfg_common_sync,
  input  logic                 cfg_sync_fall,
  input  logic                 cfg_data_fall,
  input  logic                 cfg_grant_gci,
  input  logic                 cfg_grant_en,
  input  logic                 tx_sync,
  input  logic                 rx_sync,
  input  logic [FRAME_LEN-1:0] frame_word,
  input  logic                 grant_in,
  input  logic                 rx_data,
  input  logic [2:0]           rx_slot_code,
  output logic                 tx_data,
  output logic [IDX_W-1:0]     bit_idx,
  output logic                 frame_start,
  output logic                 tx_grant
);

  // internal events, named for the checker
  logic             sync_evt;
  logic             seq_bit;
  logic [IDX_W-1:0] seq_idx;
  logic             seq_start;
  logic             seq_running;
  logic             seq_waiting;
  logic             mark_strobe;

  tdm_sync_select sync_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_common_sync (cfg_common_sync),
    .cfg_sync_fall   (cfg_sync_fall),
    .tx_sync         (tx_sync),
    .rx_sync         (rx_sync),
    .sync_evt        (sync_evt)
  );

  tdm_bit_sequencer #(
    .FRAME_LEN (FRAME_LEN),
    .IDX_W     (IDX_W)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_evt    (sync_evt),
    .cfg_delay   (cfg_delay),
    .frame_word  (frame_word),
    .seq_bit     (seq_bit),
    .seq_idx     (seq_idx),
    .seq_start   (seq_start),
    .seq_running (seq_running),
    .seq_waiting (seq_waiting)
  );

  tdm_grant_unit grant_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_evt      (sync_evt),
    .cfg_grant_gci (cfg_grant_gci),
    .cfg_grant_en  (cfg_grant_en),
    .grant_in      (grant_in),
    .rx_data       (rx_data),
    .rx_slot_code  (rx_slot_code),
    .mark_strobe   (mark_strobe),
    .grant         (tx_grant)
  );

  tdm_data_launch launch_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_data_fall (cfg_data_fall),
    .rise_bit      (seq_bit),
    .tx_data       (tx_data)
  );

  assign bit_idx     = seq_idx;
  assign frame_start = seq_start;

endmodule

// File: rtl/tdm_tx_aligner_chk.sv
module tdm_tx_aligner_chk #(
  parameter int unsigned FRAME_LEN = 8,
  parameter int unsigned IDX_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_delay,
  input logic             cfg_grant_gci,
  input logic             cfg_grant_en,
  input logic             grant_in,
  input logic             sync_evt,
  input logic             seq_bit,
  input logic [IDX_W-1:0] seq_idx,
  input logic             seq_running,
  input logic             seq_waiting,
  input logic             frame_start,
  input logic             tx_grant
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  // R1: nonzero delay holds the line idle at the event edge
  a_r1_delay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && cfg_delay != 2'd0) |=> (seq_waiting && seq_bit));

  // R2: index advances by one while shifting
  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_running && !sync_evt && seq_idx != LAST_IDX) |=>
      (seq_running && seq_idx == $past(seq_idx) + 1'b1));

  // R3: outside a frame the launched bit is idle high
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_running |-> seq_bit);

  // R4: zero-delay sync restarts at bit 0 even mid-frame
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && cfg_delay == 2'd0) |=> (frame_start && seq_idx == '0));

  // R8: pin-mode grant taken at the sync
  a_r8_pin_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && !cfg_grant_gci) |=> (tx_grant == $past(grant_in & cfg_grant_en)));

  // R8: grant holds between syncs in pin mode
  a_r8_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && !cfg_grant_gci) |=> $stable(tx_grant));

  // R9: marked-bit mode clears grant at the sync
  a_r9_mark_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && cfg_grant_gci) |=> !tx_grant);

  // R10: the strobe coincides with bit index 0
  a_r10_start_idx: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (seq_running && seq_idx == '0));

  // R11: reset leaves the block idle
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!seq_running && !seq_waiting && !tx_grant && seq_idx == '0));

endmodule

bind tdm_tx_aligner tdm_tx_aligner_chk #(
  .FRAME_LEN (FRAME_LEN),
  .IDX_W     (IDX_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_delay     (cfg_delay),
  .cfg_grant_gci (cfg_grant_gci),
  .cfg_grant_en  (cfg_grant_en),
  .grant_in      (grant_in),
  .sync_evt      (sync_evt),
  .seq_bit       (seq_bit),
  .seq_idx       (seq_idx),
  .seq_running   (seq_running),
  .seq_waiting   (seq_waiting),
  .frame_start   (frame_start),
  .tx_grant      (tx_grant)
);

// File: tb/tdm_tx_aligner_tb.sv
module tdm_tx_aligner_tb_top;

  localparam int L     = 5;
  localparam int IW    = 3;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_delay = 2'd0;
  logic          cfg_common_sync = 1'b0;
  logic          cfg_sync_fall = 1'b0;
  logic          cfg_data_fall = 1'b0;
  logic          cfg_grant_gci = 1'b0;
  logic          cfg_grant_en = 1'b0;
  logic          tx_sync = 1'b0;
  logic          rx_sync = 1'b0;
  logic [L-1:0]  frame_word = '0;
  logic          grant_in = 1'b0;
  logic          rx_data = 1'b0;
  logic [2:0]    rx_slot_code = 3'b000;
  logic          tx_data;
  logic [IW-1:0] bit_idx;
  logic          frame_start;
  logic          tx_grant;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tdm_tx_aligner #(.FRAME_LEN(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_delay),
    .cfg_common_sync(cfg_common_sync), .cfg_sync_fall(cfg_sync_fall),
    .cfg_data_fall(cfg_data_fall), .cfg_grant_gci(cfg_grant_gci),
    .cfg_grant_en(cfg_grant_en), .tx_sync(tx_sync), .rx_sync(rx_sync),
    .frame_word(frame_word), .grant_in(grant_in), .rx_data(rx_data),
    .rx_slot_code(rx_slot_code), .tx_data(tx_data), .bit_idx(bit_idx),
    .frame_start(frame_start), .tx_grant(tx_grant)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected line value k clocks after the event edge
  function automatic logic e_bit(input int k, input int d, input logic [L-1:0] w);
    if (k >= d && k < d + L) return w[k-d];
    return 1'b1;
  endfunction

  function automatic int e_idx(input int k, input int d);
    if (k >= d && k < d + L) return k - d;
    return 0;
  endfunction

  // one frame, sync driven on the chosen line, the other line pulsed mid-frame
  task automatic run_frame(input int d, input logic [L-1:0] w,
                           input logic sf, input logic df, input logic cm);
    @(posedge clk); #1;
    cfg_delay = 2'(d); cfg_sync_fall = sf; cfg_data_fall = df;
    cfg_common_sync = cm; frame_word = w;
    if (cm) rx_sync = 1'b1; else tx_sync = 1'b1;
    for (int k = 0; k <= d + L + 1; k++) begin
      @(posedge clk); #1;
      if (k == 0) begin tx_sync = 1'b0; rx_sync = 1'b0; end
      if (k == 1) begin if (cm) tx_sync = 1'b1; else rx_sync = 1'b1; end  // R5 ignored line
      if (k == 2) begin tx_sync = 1'b0; rx_sync = 1'b0; end
      #1;
      check("R7 early", 32'(tx_data), 32'(df ? e_bit(k-1, d, w) : e_bit(k, d, w)));
      #5;
      check("R1/R3/R5 data", 32'(tx_data), 32'(e_bit(k, d, w)));
      check("R2 bit_idx", 32'(bit_idx), 32'(e_idx(k, d)));
      check("R10 frame_start", 32'(frame_start), 32'(k == d));
    end
  endtask

  // second sync three clocks after the first
  task automatic run_abort(input int d2, input logic [L-1:0] w1, input logic [L-1:0] w2);
    @(posedge clk); #1;
    cfg_delay = 2'd1; cfg_sync_fall = 1'b0; cfg_data_fall = 1'b0;
    cfg_common_sync = 1'b0; frame_word = w1; tx_sync = 1'b1;
    for (int k = 0; k <= 3 + d2 + L + 1; k++) begin
      @(posedge clk); #1;
      if (k == 0) tx_sync = 1'b0;
      if (k == 2) begin tx_sync = 1'b1; cfg_delay = 2'(d2); frame_word = w2; end
      if (k == 3) tx_sync = 1'b0;
      #6;
      if (k < 3) begin
        check("R4 first", 32'(tx_data), 32'(e_bit(k, 1, w1)));
      end else begin
        check("R4 restart data", 32'(tx_data), 32'(e_bit(k-3, d2, w2)));
        check("R4 restart idx", 32'(bit_idx), 32'(e_idx(k-3, d2)));
        check("R4 restart start", 32'(frame_start), 32'(k - 3 == d2));
      end
    end
  endtask

  // sync high only from just after a falling edge to just after the next one
  task automatic run_sync_edge(input logic sf, input logic [L-1:0] w);
    int ev;
    ev = sf ? 1 : 0;
    @(posedge clk); #1;
    cfg_delay = 2'd0; cfg_sync_fall = sf; cfg_data_fall = 1'b0;
    cfg_common_sync = 1'b0; frame_word = w;
    #5 tx_sync = 1'b1;
    @(posedge clk); #6 tx_sync = 1'b0;
    #1;
    for (int k = 0; k <= L + 1; k++) begin
      if (k > 0) begin @(posedge clk); #7; end
      check("R6 data", 32'(tx_data), 32'(e_bit(k - ev, 0, w)));
      check("R6 start", 32'(frame_start), 32'(k == ev));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_err++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] words [3];
    words[0] = 5'b10110; words[1] = 5'b01001; words[2] = 5'b11100;

    // R11 reset state
    repeat (3) @(posedge clk);
    #7;
    check("R11 tx_data", 32'(tx_data), 32'd1);
    check("R11 bit_idx", 32'(bit_idx), 32'd0);
    check("R11 frame_start", 32'(frame_start), 32'd0);
    check("R11 grant", 32'(tx_grant), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 R2 R3 R5 R7 R10 sweep
    for (int d = 0; d < 4; d++)
      for (int cfg = 0; cfg < 8; cfg++)
        for (int wi = 0; wi < 3; wi++)
          run_frame(d, words[wi], cfg[0], cfg[1], cfg[2]);

    // R4 abort for every second delay
    for (int d2 = 0; d2 < 4; d2++) run_abort(d2, 5'b00000, words[d2 % 3]);

    // R6 sampling edge
    run_sync_edge(1'b0, words[0]);
    run_sync_edge(1'b1, words[1]);
    cfg_sync_fall = 1'b0;

    // R8 pin grant
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      cfg_grant_gci = 1'b0; cfg_grant_en = c[0]; grant_in = c[1];
      cfg_delay = 2'd0; cfg_common_sync = 1'b0; tx_sync = 1'b1;
      @(posedge clk); #1;
      tx_sync = 1'b0; grant_in = ~c[1];
      #6 check("R8 sampled", 32'(tx_grant), 32'(c[0] & c[1]));
      repeat (3) @(posedge clk);
      #7 check("R8 held", 32'(tx_grant), 32'(c[0] & c[1]));
      repeat (L) @(posedge clk);
    end

    // R9 marked receive bit; grant is 1 from the last pin-mode frame
    for (int v = 0; v < 2; v++) begin
      @(posedge clk); #1;
      cfg_grant_gci = 1'b0; cfg_grant_en = 1'b1; grant_in = 1'b1; tx_sync = 1'b1;
      @(posedge clk); #1 tx_sync = 1'b0;
      repeat (L) @(posedge clk);
      #1;
      cfg_grant_gci = 1'b1; tx_sync = 1'b1; grant_in = 1'b1;
      @(posedge clk); #1 tx_sync = 1'b0;
      #6 check("R9 cleared", 32'(tx_grant), 32'd0);
      @(posedge clk); #1 rx_slot_code = 3'b110; rx_data = 1'b1;
      @(posedge clk); #7 check("R9 other code", 32'(tx_grant), 32'd0);
      @(posedge clk); #1 rx_slot_code = 3'b111; rx_data = v[0];
      @(posedge clk); #1 rx_slot_code = 3'b000; rx_data = ~v[0];
      #6 check("R9 loaded", 32'(tx_grant), 32'(v[0]));
      @(posedge clk); #1 rx_slot_code = 3'b111;
      @(posedge clk); #1 rx_slot_code = 3'b000;
      #6 check("R9 second strobe", 32'(tx_grant), 32'(v[0]));
      repeat (L) @(posedge clk);
    end

    // R11 mid-frame reset with grant set
    @(posedge clk); #1;
    cfg_grant_gci = 1'b0; cfg_grant_en = 1'b1; grant_in = 1'b1;
    cfg_delay = 2'd0; frame_word = 5'b00000; tx_sync = 1'b1;
    @(posedge clk); #1 tx_sync = 1'b0;
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #7;
    check("R11 mid tx_data", 32'(tx_data), 32'd1);
    check("R11 mid bit_idx", 32'(bit_idx), 32'd0);
    check("R11 mid grant", 32'(tx_grant), 32'd0);
    check("R11 mid start", 32'(frame_start), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule